// File: doc/BRIEF.md
# Power-on strap capture and frequency select

This block runs the configuration phase of a clock generator's dual-purpose pins. When the supply becomes valid it holds five shared pins in the high-impedance state for a programmable window, measured in reference-clock cycles. At the end of the window it captures their levels once as configuration straps and then turns those pins into clock outputs. The straps stay fixed until the supply is lost again.

The captured straps decide three things. The mode strap assigns two further shared pins either as clock outputs or as active-low control inputs (power-down and CPU clock stop). The swing strap selects the CPU output swing. The three frequency straps give the default frequency code. A register override can replace that code. The selected code is registered, decoded into nominal CPU and PCI frequencies, and every change of the code is marked by a one-cycle pulse so that a downstream synthesizer can start a smooth transition.

Top module: `strap_capture_top`

## Requirements
- R1: While `por_n` is low, `straps_valid`, `strap_oe`, `strap_q`, `shr_a_oe`, `shr_b_oe`, `pwrdn_req`, `cpu_stop_req`, `freq_code` and `freq_chg` are all zero.
- R2: After `por_n` rises, `straps_valid` rises on rising clock edge number WINDOW_CYC+2 (two reset-synchronizer stages plus the window). All five `strap_oe` bits are 0 before that edge and 1 from it onward.
- R3: `strap_q` takes the `pin_lvl` value present at that edge. The bit order is: 0 = FS0, 1 = FS1, 2 = FS2, 3 = mode, 4 = swing select.
- R4: Once `straps_valid` is 1, changes on `pin_lvl` have no effect on `strap_q`, and `straps_valid` stays 1, until `por_n` goes low.
- R5: With mode strap 0, `shr_a_oe` and `shr_b_oe` are 0, `pwrdn_req` equals NOT `shr_a_in_n`, and `cpu_stop_req` equals NOT `shr_b_in_n`. With mode strap 1, both output enables are 1 and both requests are 0.
- R6: While `straps_valid` is 0, `pwrdn_req` and `cpu_stop_req` are 0 and both shared-pin output enables are 0.
- R7: The selected code is `ovr_code` when `ovr_use` is 1, and otherwise {FS2,FS1,FS0} from `strap_q`. `freq_code` takes the selected code on the clock edge after the selection, but only while `straps_valid` is 1.
- R8: `freq_chg` is 1 for exactly those cycles in which `freq_code` differs from its value in the previous cycle. This includes the first load from the reset value 000.
- R9: `cpu_khz`/`pci_khz` decode `freq_code` as follows: 000→50000/25000, 001→75000/32000, 010→83300/41650, 011→68500/34250, 100→55000/27500, 101→75000/37500, 110→60000/30000, 111→66800/33400.
- R10: `swing_low` equals strap bit 4 once valid, and is 0 before.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| por_n | input | 1 | Supply-valid indication, active low reset, asynchronous |
| pin_lvl | input | 5 | Raw levels of the five dual-purpose pins |
| shr_a_in_n | input | 1 | Shared pin A level, active-low power-down when used as input |
| shr_b_in_n | input | 1 | Shared pin B level, active-low CPU stop when used as input |
| ovr_use | input | 1 | Register override enable for the frequency code |
| ovr_code | input | 3 | Register override frequency code |
| strap_oe | output | 5 | Output enables of the dual-purpose pins |
| strap_q | output | 5 | Latched strap values |
| straps_valid | output | 1 | Straps captured |
| shr_a_oe | output | 1 | Shared pin A driven as clock output |
| shr_b_oe | output | 1 | Shared pin B driven as clock output |
| pwrdn_req | output | 1 | Power-down request |
| cpu_stop_req | output | 1 | CPU clock stop request |
| swing_low | output | 1 | Reduced CPU swing selected |
| freq_code | output | 3 | Active frequency code |
| freq_chg | output | 1 | One-cycle pulse on code change |
| cpu_khz | output | 17 | Nominal CPU/memory frequency in kHz |
| pci_khz | output | 17 | Nominal PCI frequency in kHz |

## Verification
The hardest situation to reach from the ports is the single capture edge. The pin levels must be shown to be sampled on exactly edge WINDOW_CYC+2 and on no other edge. For each of the 32 strap patterns, the stimulus drives the complement of the pattern for the whole window and switches to the true pattern only in the half-cycle just before the capture edge. It then flips the pins again afterwards. Each pattern is followed by a sweep of all eight override codes and a return to the strap code, so that the change pulse is seen both for real changes and for repeated codes.

// File: rtl/strap_cfg_pkg.sv
package strap_cfg_pkg;
  localparam int STRAP_N   = 5;
  localparam int MODE_IDX  = 3;
  localparam int SWING_IDX = 4;
  localparam int CODE_W    = 3;
  localparam int KHZ_W     = 17;

  typedef logic [CODE_W-1:0] fcode_t;

  typedef struct packed {
    logic [KHZ_W-1:0] cpu;
    logic [KHZ_W-1:0] pci;
  } khz_pair_t;

  typedef enum logic {ROLE_CTRL_IN = 1'b0, ROLE_CLK_OUT = 1'b1} pin_role_e;

  function automatic khz_pair_t decode_fcode(fcode_t c);
    khz_pair_t r;
    case (c)
      3'd0:    begin r.cpu = 17'd50000; r.pci = 17'd25000; end
      3'd1:    begin r.cpu = 17'd75000; r.pci = 17'd32000; end
      3'd2:    begin r.cpu = 17'd83300; r.pci = 17'd41650; end
      3'd3:    begin r.cpu = 17'd68500; r.pci = 17'd34250; end
      3'd4:    begin r.cpu = 17'd55000; r.pci = 17'd27500; end
      3'd5:    begin r.cpu = 17'd75000; r.pci = 17'd37500; end
      3'd6:    begin r.cpu = 17'd60000; r.pci = 17'd30000; end
      default: begin r.cpu = 17'd66800; r.pci = 17'd33400; end
    endcase
    return r;
  endfunction
endpackage

// File: rtl/por_release_sync.sv
module por_release_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic por_n,
  output logic rst_n
);
  logic [STAGES-1:0] sr_q;
  logic [STAGES-1:0] sr_d;

  always_comb begin
    sr_d = {sr_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) sr_q <= '0;
    else        sr_q <= sr_d;
  end

  assign rst_n = sr_q[STAGES-1];
endmodule

// File: rtl/strap_window.sv
module strap_window #(
  parameter int WINDOW_CYC = 28636,
  parameter int STRAP_N    = 5
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [STRAP_N-1:0] pin_lvl,
  output logic [STRAP_N-1:0] strap_q,
  output logic               valid
);
  localparam int CNT_W = (WINDOW_CYC > 2) ? $clog2(WINDOW_CYC) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(WINDOW_CYC - 1);

  logic [CNT_W-1:0]   cnt_q, cnt_d;
  logic               valid_q, valid_d;
  logic [STRAP_N-1:0] strap_d, strap_r;
  logic               cnt_en;

  assign cnt_en = !valid_q;

  always_comb begin
    cnt_d   = cnt_q;
    valid_d = valid_q;
    strap_d = strap_r;
    if (cnt_en) begin
      if (cnt_q == LAST) begin
        valid_d = 1'b1;
        strap_d = pin_lvl;
      end else begin
        cnt_d = cnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      valid_q <= 1'b0;
      strap_r <= '0;
    end else begin
      cnt_q   <= cnt_d;
      valid_q <= valid_d;
      strap_r <= strap_d;
    end
  end

  assign strap_q = strap_r;
  assign valid   = valid_q;
endmodule

// File: rtl/freq_source.sv
module freq_source
  import strap_cfg_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      valid,
  input  fcode_t    strap_fs,
  input  logic      ovr_use,
  input  fcode_t    ovr_code,
  output fcode_t    code,
  output logic      chg,
  output khz_pair_t khz
);
  fcode_t sel, code_q, code_d;
  logic   chg_q, chg_d;
  logic   upd_en;

  assign sel    = ovr_use ? ovr_code : strap_fs;
  assign upd_en = valid && (sel != code_q);

  always_comb begin
    code_d = code_q;
    chg_d  = 1'b0;
    if (upd_en) begin
      code_d = sel;
      chg_d  = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      code_q <= '0;
      chg_q  <= 1'b0;
    end else begin
      code_q <= code_d;
      chg_q  <= chg_d;
    end
  end

  assign code = code_q;
  assign chg  = chg_q;
  assign khz  = decode_fcode(code_q);
endmodule

// File: rtl/shared_pin_map.sv
module shared_pin_map
  import strap_cfg_pkg::*;
(
  input  logic valid,
  input  logic mode_strap,
  input  logic a_in_n,
  input  logic b_in_n,
  output logic a_oe,
  output logic b_oe,
  output logic pwrdn_req,
  output logic stop_req
);
  pin_role_e role;

  always_comb begin
    role      = mode_strap ? ROLE_CLK_OUT : ROLE_CTRL_IN;
    a_oe      = 1'b0;
    b_oe      = 1'b0;
    pwrdn_req = 1'b0;
    stop_req  = 1'b0;
    if (valid) begin
      if (role == ROLE_CLK_OUT) begin
        a_oe = 1'b1;
        b_oe = 1'b1;
      end else begin
        pwrdn_req = !a_in_n;
        stop_req  = !b_in_n;
      end
    end
  end
endmodule

// File: rtl/strap_capture_top.sv
module strap_capture_top
  import strap_cfg_pkg::*;
#(
  parameter int WINDOW_CYC = 28636
) (
  input  logic               clk,
  input  logic               por_n,
  input  logic [STRAP_N-1:0] pin_lvl,
  input  logic               shr_a_in_n,
  input  logic               shr_b_in_n,
  input  logic               ovr_use,
  input  logic [CODE_W-1:0]  ovr_code,
  output logic [STRAP_N-1:0] strap_oe,
  output logic [STRAP_N-1:0] strap_q,
  output logic               straps_valid,
  output logic               shr_a_oe,
  output logic               shr_b_oe,
  output logic               pwrdn_req,
  output logic               cpu_stop_req,
  output logic               swing_low,
  output logic [CODE_W-1:0]  freq_code,
  output logic               freq_chg,
  output logic [KHZ_W-1:0]   cpu_khz,
  output logic [KHZ_W-1:0]   pci_khz
);
  logic      rst_n;
  khz_pair_t khz;

  por_release_sync #(.STAGES(2)) u_sync (
    .clk(clk), .por_n(por_n), .rst_n(rst_n)
  );

  strap_window #(.WINDOW_CYC(WINDOW_CYC), .STRAP_N(STRAP_N)) u_win (
    .clk(clk), .rst_n(rst_n), .pin_lvl(pin_lvl),
    .strap_q(strap_q), .valid(straps_valid)
  );

  for (genvar i = 0; i < STRAP_N; i++) begin : g_oe
    assign strap_oe[i] = straps_valid;
  end

  shared_pin_map u_map (
    .valid(straps_valid), .mode_strap(strap_q[MODE_IDX]),
    .a_in_n(shr_a_in_n), .b_in_n(shr_b_in_n),
    .a_oe(shr_a_oe), .b_oe(shr_b_oe),
    .pwrdn_req(pwrdn_req), .stop_req(cpu_stop_req)
  );

  assign swing_low = straps_valid && strap_q[SWING_IDX];

  freq_source u_freq (
    .clk(clk), .rst_n(rst_n), .valid(straps_valid),
    .strap_fs(strap_q[CODE_W-1:0]), .ovr_use(ovr_use), .ovr_code(ovr_code),
    .code(freq_code), .chg(freq_chg), .khz(khz)
  );

  assign cpu_khz = khz.cpu;
  assign pci_khz = khz.pci;
endmodule

// File: rtl/strap_capture_chk.sv
module strap_capture_chk (
  input logic       clk,
  input logic       por_n,
  input logic       straps_valid,
  input logic [4:0] strap_q,
  input logic [4:0] strap_oe,
  input logic       shr_a_oe,
  input logic       shr_b_oe,
  input logic       pwrdn_req,
  input logic       cpu_stop_req,
  input logic       ovr_use,
  input logic [2:0] ovr_code,
  input logic [2:0] freq_code,
  input logic       freq_chg
);
  // R4: once captured, straps and the valid flag do not move
  p_straps_hold_r4: assert property (@(posedge clk) disable iff (!por_n)
    straps_valid |=> straps_valid && $stable(strap_q));

  // R2: pin buffers follow the capture
  p_oe_follow_r2: assert property (@(posedge clk) disable iff (!por_n)
    (strap_oe == {5{straps_valid}}));

  // R6: no control requests or shared outputs before capture
  p_ctrl_idle_r6: assert property (@(posedge clk) disable iff (!por_n)
    !straps_valid |-> !pwrdn_req && !cpu_stop_req && !shr_a_oe && !shr_b_oe);

  // R5: a shared pin is never both an output and an active input
  p_role_excl_r5: assert property (@(posedge clk) disable iff (!por_n)
    !(shr_a_oe && pwrdn_req) && !(shr_b_oe && cpu_stop_req));

  // R7: override code applied one edge later
  p_override_r7: assert property (@(posedge clk) disable iff (!por_n)
    straps_valid && $past(straps_valid) && $past(ovr_use) |-> freq_code == $past(ovr_code));

  // R8: pulse marks exactly the cycles of a new code
  p_chg_pulse_r8: assert property (@(posedge clk) disable iff (!por_n)
    1'b1 |-> (freq_chg == (freq_code != $past(freq_code))));
endmodule

bind strap_capture_top strap_capture_chk u_chk (
  .clk(clk), .por_n(por_n), .straps_valid(straps_valid), .strap_q(strap_q),
  .strap_oe(strap_oe), .shr_a_oe(shr_a_oe), .shr_b_oe(shr_b_oe),
  .pwrdn_req(pwrdn_req), .cpu_stop_req(cpu_stop_req), .ovr_use(ovr_use),
  .ovr_code(ovr_code), .freq_code(freq_code), .freq_chg(freq_chg)
);

// File: tb/strap_capture_top_tb.sv
module strap_capture_top_tb;
  localparam int CLK_PERIOD = 10;
  localparam int WIN = 40;

  logic clk = 1'b0;
  logic por_n;
  logic [4:0] pin_lvl;
  logic shr_a_in_n, shr_b_in_n, ovr_use;
  logic [2:0] ovr_code;
  logic [4:0] strap_oe, strap_q;
  logic straps_valid, shr_a_oe, shr_b_oe, pwrdn_req, cpu_stop_req, swing_low;
  logic [2:0] freq_code;
  logic freq_chg;
  logic [16:0] cpu_khz, pci_khz;

  int vectors = 0;
  int fails = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  strap_capture_top #(.WINDOW_CYC(WIN)) u_dut (
    .clk(clk), .por_n(por_n), .pin_lvl(pin_lvl), .shr_a_in_n(shr_a_in_n),
    .shr_b_in_n(shr_b_in_n), .ovr_use(ovr_use), .ovr_code(ovr_code),
    .strap_oe(strap_oe), .strap_q(strap_q), .straps_valid(straps_valid),
    .shr_a_oe(shr_a_oe), .shr_b_oe(shr_b_oe), .pwrdn_req(pwrdn_req),
    .cpu_stop_req(cpu_stop_req), .swing_low(swing_low), .freq_code(freq_code),
    .freq_chg(freq_chg), .cpu_khz(cpu_khz), .pci_khz(pci_khz)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  function automatic logic [16:0] exp_cpu(input logic [2:0] c);
    int base [8] = '{50000, 75000, 83300, 68500, 55000, 75000, 60000, 66800};
    return 17'(base[c]);
  endfunction

  function automatic logic [16:0] exp_pci(input logic [2:0] c);
    int base [8] = '{25000, 32000, 41650, 34250, 27500, 37500, 30000, 33400};
    return 17'(base[c]);
  endfunction

  task automatic check_code(input logic [2:0] exp, input logic exp_pulse);
    chk("R7 freq_code", 32'(freq_code), 32'(exp));
    chk("R8 freq_chg", 32'(freq_chg), 32'(exp_pulse));
    chk("R9 cpu_khz", 32'(cpu_khz), 32'(exp_cpu(exp)));
    chk("R9 pci_khz", 32'(pci_khz), 32'(exp_pci(exp)));
  endtask

  task automatic run_pattern(input logic [4:0] tgt);
    logic [2:0] cur;
    logic mode;
    mode = tgt[3];
    @(negedge clk);
    por_n = 1'b0;
    pin_lvl = ~tgt;
    ovr_use = 1'b0;
    ovr_code = 3'd0;
    shr_a_in_n = 1'b0;
    shr_b_in_n = 1'b0;
    repeat (2) @(negedge clk);
    // R1 reset state
    chk("R1 valid", 32'(straps_valid), 0);
    chk("R1 strap_q", 32'(strap_q), 0);
    chk("R1 oe", 32'({strap_oe, shr_a_oe, shr_b_oe}), 0);
    chk("R1 freq", 32'({freq_code, freq_chg}), 0);
    chk("R6 req", 32'({pwrdn_req, cpu_stop_req}), 0);
    chk("R10 swing", 32'(swing_low), 0);
    por_n = 1'b1;
    for (int k = 1; k <= WIN + 2; k++) begin
      @(posedge clk);
      @(negedge clk);
      if (k < WIN + 2) begin
        if (k == 1 || k == WIN + 1) begin
          chk("R2 early valid", 32'(straps_valid), 0);
          chk("R2 early oe", 32'(strap_oe), 0);
          chk("R6 early req", 32'({pwrdn_req, cpu_stop_req, shr_a_oe, shr_b_oe}), 0);
        end
        if (k == WIN + 1) pin_lvl = tgt;
      end else begin
        chk("R2 valid edge", 32'(straps_valid), 1);
        chk("R2 oe on", 32'(strap_oe), 32'h1f);
        chk("R3 strap_q", 32'(strap_q), 32'(tgt));
        chk("R10 swing", 32'(swing_low), 32'(tgt[4]));
        chk("R7 not yet loaded", 32'(freq_code), 0);
      end
    end
    pin_lvl = ~tgt;
    @(negedge clk);
    check_code(tgt[2:0], tgt[2:0] != 3'd0);
    cur = tgt[2:0];
    @(negedge clk);
    chk("R4 strap_q", 32'(strap_q), 32'(tgt));
    chk("R4 valid", 32'(straps_valid), 1);
    chk("R8 no pulse", 32'(freq_chg), 0);
    // R5 shared pins, all input level combinations
    for (int p = 0; p < 4; p++) begin
      shr_a_in_n = p[0];
      shr_b_in_n = p[1];
      #1;
      chk("R5 a_oe", 32'(shr_a_oe), 32'(mode));
      chk("R5 b_oe", 32'(shr_b_oe), 32'(mode));
      chk("R5 pwrdn", 32'(pwrdn_req), 32'(!mode && !p[0]));
      chk("R5 stop", 32'(cpu_stop_req), 32'(!mode && !p[1]));
    end
    // R7/R8/R9 override sweep
    ovr_use = 1'b1;
    for (int c = 0; c < 8; c++) begin
      ovr_code = 3'(c);
      @(negedge clk);
      check_code(3'(c), 3'(c) != cur);
      cur = 3'(c);
    end
    @(negedge clk);
    check_code(cur, 1'b0);
    ovr_use = 1'b0;
    @(negedge clk);
    check_code(tgt[2:0], tgt[2:0] != cur);
    chk("R4 strap_q end", 32'(strap_q), 32'(tgt));
  endtask

  initial begin
    por_n = 1'b0;
    pin_lvl = '0;
    shr_a_in_n = 1'b1;
    shr_b_in_n = 1'b1;
    ovr_use = 1'b0;
    ovr_code = '0;
    for (int s = 0; s < 32; s++) run_pattern(5'(s));
    if (!done) begin
      done = 1;
      $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end
endmodule